// File: doc/BRIEF.md
# Sorted Array Seeker

This block looks for an 8-bit unsigned target value in a sorted table of 32 entries. The table sits in an external RAM that registers its read address, so a word appears on the read data one clock after its address is presented. The block drives that address and reads the returned word. It narrows a window of indices by halving until the middle entry equals the target or the window is empty.

A search begins when the asynchronous start request, after passing through a clock-domain synchronizer, is seen high while the block is idle. The target is captured at that moment. At completion the block raises a done flag. It raises a found flag together with the matching index only when the value exists in the table. These results stay up for as long as the start request is held. Releasing the request returns the block to idle.

Top module: `sorted_seeker`

## Requirements
- R1: A synchronous active-high reset clears done, found and location to 0 at the next rising edge and abandons any search in progress. A later search then runs normally.
- R2: The start request passes through a two-stage synchronizer. When it goes high just after a rising edge, the search is accepted on the third rising edge that follows.
- R3: The window opens as indices 0 to 31. Each probe index is floor((low+high)/2), and the probe index appears on the RAM address port. The first probe, at index 15, is on the address port after the fourth edge.
- R4: Each probe takes three cycles: issue, wait for the registered RAM data, compare. A target found on probe k raises done after edge 3+3k, counting from the edge that first captures start.
- R5: Comparisons are unsigned. A probed entry greater than the target moves the window below the probe; a smaller entry moves it above the probe.
- R6: On a match, done and found go high in the same cycle, and location gives the matching index.
- R7: A miss raises done with found low and location 0. This happens either one edge after the last probe empties the window (edge 3+3k+1), or on the compare edge itself (3+3k) when the entry at index 0 is greater than the target.
- R8: While start stays high after completion, done, found and location hold. After start is released, done falls on the third rising edge.
- R9: A start request that is released before completion still lets the search finish. Done is then high for exactly one cycle.
- R10: The target is sampled when the search is accepted. Changes on the target input during a search do not affect its result.
- R11: Found is never high while done is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_req | input | 1 | Asynchronous search request |
| target | input | 8 | Value to look for |
| ram_addr | output | 5 | Read address to the table RAM |
| ram_rdata | input | 8 | Word from the RAM, one cycle after its address |
| loc | output | 5 | Index of the match, 0 when none |
| done | output | 1 | Search finished |
| found | output | 1 | Target present in the table |

## Verification
Two events can meet in a single cycle: completion of the search, and the release of start reaching the controller through the synchronizer. The bench provokes this by dropping start one cycle after raising it. The search is then still running when the synchronized release arrives. The bench expects done to rise on the predicted completion edge and fall on the very next edge, so the release is neither lost nor allowed to cut the search short. A behavioural search over the same table predicts the completion edge and result for every target, and these are compared on each clock.

// File: rtl/sp_pkg.sv
package sp_pkg;
   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_ISSUE = 3'd1,
      ST_WAIT  = 3'd2,
      ST_CMP   = 3'd3,
      ST_HOLD  = 3'd4
   } sp_state_t;

   // relation of the probed entry to the target
   typedef enum logic [1:0] {
      REL_EQ = 2'd0,
      REL_LT = 2'd1,
      REL_GT = 2'd2
   } sp_rel_t;
endpackage

// File: rtl/sp_sync.sv
module sp_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic d,
   output logic q
);
   generate
      if (STAGES < 1) begin : g_bad_stages
         $error("sp_sync: STAGES must be at least 1");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   generate
      if (STAGES == 1) begin : g_single
         always_ff @(posedge clk) begin
            if (rst) chain[0] <= 1'b0;
            else     chain[0] <= d;
         end
      end else begin : g_multi
         always_ff @(posedge clk) begin
            if (rst) chain <= '0;
            else     chain <= {chain[STAGES-2:0], d};
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/sp_path.sv
module sp_path
   import sp_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 5
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              init,
   input  logic              load_probe,
   input  logic              go_lo,
   input  logic              go_hi,
   input  logic [DATA_W-1:0] target,
   input  logic [DATA_W-1:0] rdata,
   output logic [ADDR_W-1:0] probe,
   output logic              empty,
   output logic              probe_zero,
   output sp_rel_t           rel
);
   localparam int BND_W = ADDR_W + 1;
   localparam int SUM_W = ADDR_W + 2;
   localparam logic [BND_W-1:0] TOP_IDX = BND_W'((1 << ADDR_W) - 1);

   logic [BND_W-1:0]  low_q, high_q;
   logic [DATA_W-1:0] tgt_q;
   logic [SUM_W-1:0]  sum;
   logic [ADDR_W-1:0] mid;

   assign sum = SUM_W'(low_q) + SUM_W'(high_q);
   assign mid = sum[ADDR_W:1];

   always_ff @(posedge clk) begin
      if (rst) begin
         low_q  <= '0;
         high_q <= TOP_IDX;
         tgt_q  <= '0;
         probe  <= '0;
      end else begin
         if (init) begin
            low_q  <= '0;
            high_q <= TOP_IDX;
            tgt_q  <= target;
         end
         if (load_probe) probe <= mid;
         if (go_lo) high_q <= {1'b0, probe} - BND_W'(1);
         if (go_hi) low_q  <= {1'b0, probe} + BND_W'(1);
      end
   end

   assign empty      = (low_q > high_q);
   assign probe_zero = (probe == '0);

   always_comb begin
      if (rdata == tgt_q)     rel = REL_EQ;
      else if (rdata > tgt_q) rel = REL_GT;
      else                    rel = REL_LT;
   end

   // R3: a freshly issued probe lies inside the window
   p_probe_in_window_r3: assert property (@(posedge clk) disable iff (rst)
      load_probe |=> ({1'b0, probe} >= low_q) && ({1'b0, probe} <= high_q));

   // R10: captured target only changes on acceptance
   p_target_kept_r10: assert property (@(posedge clk) disable iff (rst)
      !init |=> $stable(tgt_q));
endmodule

// File: rtl/sp_ctrl.sv
module sp_ctrl
   import sp_pkg::*;
#(
   parameter int ADDR_W = 5
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              go,
   input  sp_rel_t           rel,
   input  logic              empty,
   input  logic              probe_zero,
   input  logic [ADDR_W-1:0] probe,
   output logic              init,
   output logic              load_probe,
   output logic              go_lo,
   output logic              go_hi,
   output logic              done,
   output logic              found,
   output logic [ADDR_W-1:0] loc
);
   sp_state_t st, st_n;

   always_comb begin
      st_n       = st;
      init       = 1'b0;
      load_probe = 1'b0;
      go_lo      = 1'b0;
      go_hi      = 1'b0;
      case (st)
         ST_IDLE:  if (go) begin init = 1'b1; st_n = ST_ISSUE; end
         ST_ISSUE: if (empty) st_n = ST_HOLD;
                   else begin load_probe = 1'b1; st_n = ST_WAIT; end
         ST_WAIT:  st_n = ST_CMP;
         ST_CMP: begin
            case (rel)
               REL_EQ: st_n = ST_HOLD;
               REL_GT: if (probe_zero) st_n = ST_HOLD;
                       else begin go_lo = 1'b1; st_n = ST_ISSUE; end
               default: begin go_hi = 1'b1; st_n = ST_ISSUE; end
            endcase
         end
         ST_HOLD:  if (!go) st_n = ST_IDLE;
         default:  st_n = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         st    <= ST_IDLE;
         done  <= 1'b0;
         found <= 1'b0;
         loc   <= '0;
      end else begin
         st <= st_n;
         if (st != ST_HOLD && st_n == ST_HOLD) begin
            done <= 1'b1;
            if (st == ST_CMP && rel == REL_EQ) begin
               found <= 1'b1;
               loc   <= probe;
            end
         end else if (st == ST_HOLD && st_n == ST_IDLE) begin
            done  <= 1'b0;
            found <= 1'b0;
            loc   <= '0;
         end
      end
   end

   // R11
   p_found_needs_done_r11: assert property (@(posedge clk) disable iff (rst)
      found |-> done);

   // R4: compare only after the wait cycle, with the address unchanged
   p_cmp_after_wait_r4: assert property (@(posedge clk) disable iff (rst)
      (st == ST_CMP) |-> ($past(st) == ST_WAIT) && $stable(probe));

   // R8: results hold while start stays high
   p_hold_keeps_r8: assert property (@(posedge clk) disable iff (rst)
      (st == ST_HOLD && go) |=> done && $stable(found) && $stable(loc));

   // R8: release clears the results
   p_release_clears_r8: assert property (@(posedge clk) disable iff (rst)
      (st == ST_HOLD && !go) |=> !done && !found);
endmodule

// File: rtl/sorted_seeker.sv
module sorted_seeker
   import sp_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int ADDR_W      = 5,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start_req,
   input  logic [DATA_W-1:0] target,
   output logic [ADDR_W-1:0] ram_addr,
   input  logic [DATA_W-1:0] ram_rdata,
   output logic [ADDR_W-1:0] loc,
   output logic              done,
   output logic              found
);
   generate
      if (DATA_W < 1) begin : g_bad_data
         $error("sorted_seeker: DATA_W must be positive");
      end
      if (ADDR_W < 1 || ADDR_W > 16) begin : g_bad_addr
         $error("sorted_seeker: ADDR_W out of range");
      end
   endgenerate

   logic    go, init, load_probe, go_lo, go_hi, empty, probe_zero;
   sp_rel_t rel;
   logic [ADDR_W-1:0] probe;

   sp_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst(rst), .d(start_req), .q(go));

   sp_path #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_path (
      .clk(clk), .rst(rst), .init(init), .load_probe(load_probe),
      .go_lo(go_lo), .go_hi(go_hi), .target(target), .rdata(ram_rdata),
      .probe(probe), .empty(empty), .probe_zero(probe_zero), .rel(rel));

   sp_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
      .clk(clk), .rst(rst), .go(go), .rel(rel), .empty(empty),
      .probe_zero(probe_zero), .probe(probe), .init(init),
      .load_probe(load_probe), .go_lo(go_lo), .go_hi(go_hi),
      .done(done), .found(found), .loc(loc));

   assign ram_addr = probe;
endmodule

// File: tb/sorted_seeker_tb.sv
module sp_ram_model #(
   parameter int AW = 5,
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic [AW-1:0] addr,
   output logic [DW-1:0] rdata
);
   logic [DW-1:0] mem [0:(1<<AW)-1];
   logic [AW-1:0] addr_q;
   initial begin
      for (int i = 0; i < (1 << AW); i++) mem[i] = DW'(8 * i + 7);
      addr_q = '0;
   end
   always_ff @(posedge clk) addr_q <= addr;
   assign rdata = mem[addr_q];
endmodule

module sorted_seeker_tb;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       start_req = 1'b0;
   logic [7:0] target = 8'd0;
   logic [4:0] ram_addr, loc;
   logic [7:0] ram_rdata;
   logic       done, found;

   int checks = 0;
   int fails  = 0;
   bit ended  = 1'b0;

   always #2 clk = ~clk;

   sorted_seeker u_dut (
      .clk(clk), .rst(rst), .start_req(start_req), .target(target),
      .ram_addr(ram_addr), .ram_rdata(ram_rdata), .loc(loc),
      .done(done), .found(found));

   sp_ram_model #(.AW(5), .DW(8)) u_ram (
      .clk(clk), .addr(ram_addr), .rdata(ram_rdata));

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic check_outs(input string req, input bit e_done,
                             input bit e_found, input int e_loc);
      check(done == e_done, req, "done", done, e_done);
      check(found == e_found, req, "found", found, e_found);
      check(int'(loc) == e_loc, req, "loc", loc, e_loc);
   endtask

   function automatic int elem(input int i);
      return 8 * i + 7;
   endfunction

   // behavioural search: completion edge, result
   task automatic predict(input int t, output int tdone, output bit hit,
                          output int where);
      int lo = 0, hi = 31, k = 0, mid;
      hit = 1'b0; where = 0; tdone = 0;
      forever begin
         if (lo > hi) begin tdone = 3 + 3 * k + 1; return; end
         mid = (lo + hi) / 2;
         k++;
         if (elem(mid) == t) begin
            hit = 1'b1; where = mid; tdone = 3 + 3 * k; return;
         end else if (elem(mid) > t) begin
            if (mid == 0) begin tdone = 3 + 3 * k; return; end
            hi = mid - 1;
         end else lo = mid + 1;
      end
   endtask

   // mode 0 normal, 1 early release (R9), 2 target disturbed (R10)
   task automatic search(input int t, input int mode, input string req);
      int  tdone, where;
      bit  hit, e_done;
      predict(t, tdone, hit, where);
      @(posedge clk); #1;
      start_req = 1'b1;
      target    = 8'(t);
      for (int n = 1; n <= tdone + 3; n++) begin
         @(posedge clk); #1;
         if (mode == 1 && n == 1) start_req = 1'b0;
         if (mode == 2 && n == 4) target = ~8'(t);
         #1;
         if (mode == 1) e_done = (n == tdone);
         else           e_done = (n >= tdone);
         check_outs(req, e_done, e_done && hit, (e_done && hit) ? where : 0);
         if (n == 4) check(ram_addr == 5'd15, "R3", "first probe", ram_addr, 15);
      end
      if (mode != 1) begin
         start_req = 1'b0;
         for (int m = 1; m <= 3; m++) begin
            @(posedge clk); #2;
            check_outs("R8", m < 3, (m < 3) && hit, ((m < 3) && hit) ? where : 0);
         end
      end
      repeat (2) @(posedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!ended) begin
         fails++;
         ended = 1'b1;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #2;
      check_outs("R1", 1'b0, 1'b0, 0);
      #1 rst = 1'b0;

      search(127, 0, "R4");     // first probe match
      search(135, 0, "R6");
      search(7,   0, "R6");     // index 0
      search(255, 0, "R5");     // top entry, unsigned
      search(128, 0, "R7");     // gap, window empties
      search(0,   0, "R7");     // below all, probe 0 greater
      search(8,   0, "R7");
      search(200, 0, "R7");
      search(63,  0, "R2");
      search(71,  1, "R9");     // release before completion
      search(2,   1, "R9");     // miss with early release
      search(199, 2, "R10");    // target changed mid-search

      // R1: reset during a search
      @(posedge clk); #1;
      start_req = 1'b1; target = 8'd255;
      repeat (8) @(posedge clk);
      #1 rst = 1'b1; start_req = 1'b0;
      @(posedge clk); #2;
      check_outs("R1", 1'b0, 1'b0, 0);
      repeat (20) @(posedge clk);
      #2;
      check_outs("R1", 1'b0, 1'b0, 0);
      #1 rst = 1'b0;
      search(95, 0, "R1");

      ended = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule